// File: doc/BRIEF.md
# Memory-Type Range Register File

This block stores the configuration that assigns caching types to regions of physical memory. It holds one global control register, eleven fixed-range registers, one page-attribute register, a parameterised set of variable base/mask pairs and a constant capability word. The registers sit behind a plain single-cycle register port.

Every write is checked against the legality rules of its target register. The rules cover which type codes are allowed in each byte field and which bits are reserved. A rejected write changes nothing and raises a one-cycle error pulse. Reads are registered. Variable-pair registers are returned masked to the configured physical address width.

Mask registers keep their bits above the physical address width set to one internally, so that a later range decode can treat them as implicitly matching. Range lookup itself belongs to a neighbouring block.

Top module: `memtype_regfile`

## Requirements
- R1: After reset every stored register reads zero, and the capability word at 0x0FE reads 0x500 OR NUM_VAR (0x508 by default).
- R2: A read presents its data on `rdata` in the cycle after `rd_en`. `rdata` is zero in every cycle that does not follow a read. `err` for an access appears in that same following cycle, for one cycle.
- R3: A fixed-range register is written at 0x100+k for k in 0..10. The write is accepted only if all eight byte fields are in {0,1,4,5,6}. Any other byte, including 7, causes `err` and leaves the register unchanged.
- R4: The page-attribute register at 0x1F8 accepts a write only if all eight byte fields are in {0,1,4,5,6,7}. Otherwise `err` is raised and the register is unchanged.
- R5: The control register at 0x1F0 rejects a write that sets any bit outside 0xCFF. It also rejects a write whose bits 7:0 are not in {0,1,4,5,6}.
- R6: Variable pairs start at 0x200. An even offset is a base and an odd offset is a mask, with pair n at 0x200+2n. A base write is rejected if bits 7:0 are not in {0,1,4,5,6}, if any of bits 11:8 is set, or if any bit at or above PA_WIDTH is set.
- R7: A variable mask write is rejected if any of bits 10:0 is set or any bit at or above PA_WIDTH is set.
- R8: An accepted mask is held with every bit at or above PA_WIDTH forced to one. Reads of both base and mask clear those bits, so an accepted value reads back exactly as written.
- R9: Writes to the capability word are ignored without an error, and its value never changes.
- R10: An access to an address outside the defined set reads zero, raises `err` and changes no register.
- R11: When `rd_en` and `wr_en` are both asserted to the same address in one cycle, `rdata` returns the value held before that write. `err` reflects whether the write was legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| wdata | input | 64 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 64 | Registered read data |
| err | output | 1 | One-cycle error pulse for a rejected write or unmapped access |

## Verification
A read and a write can target the same register in the same cycle. This is provoked by raising both strobes to one fixed-range address, once with a legal new value and once with an illegal one. In both cases the returned data must be the pre-write contents. `err` must match only the write's legality. A following plain read must show the new value when the write was legal and the old value when it was not.

// File: rtl/memtype_regfile.sv
module memtype_regfile #(
  parameter int PA_WIDTH = 36,
  parameter int NUM_VAR  = 8,
  parameter int ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] FIX_BASE  = 12'h100,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h1F0,
  parameter logic [ADDR_W-1:0] ATTR_ADDR = 12'h1F8,
  parameter logic [ADDR_W-1:0] CAP_ADDR  = 12'h0FE,
  parameter logic [ADDR_W-1:0] VAR_BASE  = 12'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [63:0]       rdata,
  output logic              err
);
  localparam int FIX_N  = 11;
  localparam int FIDX_W = $clog2(FIX_N);
  localparam int VIDX_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
  localparam logic [63:0] PA_KEEP = (64'd1 << PA_WIDTH) - 64'd1;
  localparam logic [63:0] HI_BITS = ~PA_KEEP;
  localparam logic [63:0] CAP_VAL = 64'h500 | 64'(NUM_VAR);
  localparam logic [63:0] CTRL_ALLOWED = 64'hCFF;
  localparam logic [ADDR_W-1:0] FIX_END = FIX_BASE + ADDR_W'(FIX_N);
  localparam logic [ADDR_W-1:0] VAR_END = VAR_BASE + ADDR_W'(2 * NUM_VAR);

  logic [63:0]                 ctrl_q, attr_q;
  logic [FIX_N-1:0][63:0]      fix_q;
  logic [NUM_VAR-1:0][63:0]    vbase_q, vmask_q;

  function automatic logic rng_ok(input logic [7:0] t);
    return (t == 8'd0) || (t == 8'd1) || (t == 8'd4) || (t == 8'd5) || (t == 8'd6);
  endfunction

  function automatic logic attr_ok(input logic [7:0] t);
    return rng_ok(t) || (t == 8'd7);
  endfunction

  function automatic logic all_rng(input logic [63:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) ok = ok & rng_ok(v[i*8 +: 8]);
    return ok;
  endfunction

  function automatic logic all_attr(input logic [63:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) ok = ok & attr_ok(v[i*8 +: 8]);
    return ok;
  endfunction

  logic [ADDR_W-1:0] fix_off, var_off;
  logic [FIDX_W-1:0] fidx;
  logic [VIDX_W-1:0] vidx;
  logic is_fix, is_var, is_mask, is_ctrl, is_attr, is_cap, hit;
  logic wr_ok;
  logic [63:0] rd_val;

  assign fix_off = addr - FIX_BASE;
  assign var_off = addr - VAR_BASE;
  assign fidx    = fix_off[FIDX_W-1:0];
  assign vidx    = var_off[VIDX_W:1];
  assign is_mask = var_off[0];
  assign is_fix  = (addr >= FIX_BASE) && (addr < FIX_END);
  assign is_var  = (addr >= VAR_BASE) && (addr < VAR_END);
  assign is_ctrl = (addr == CTRL_ADDR);
  assign is_attr = (addr == ATTR_ADDR);
  assign is_cap  = (addr == CAP_ADDR);
  assign hit     = is_fix | is_var | is_ctrl | is_attr | is_cap;

  always_comb begin
    wr_ok = 1'b0;
    if (is_fix)       wr_ok = all_rng(wdata);
    else if (is_attr) wr_ok = all_attr(wdata);
    else if (is_ctrl) wr_ok = ((wdata & ~CTRL_ALLOWED) == 64'd0) && rng_ok(wdata[7:0]);
    else if (is_cap)  wr_ok = 1'b1;
    else if (is_var) begin
      if (is_mask) wr_ok = (wdata[10:0] == 11'd0) && ((wdata & HI_BITS) == 64'd0);
      else         wr_ok = rng_ok(wdata[7:0]) && (wdata[11:8] == 4'd0) && ((wdata & HI_BITS) == 64'd0);
    end
  end

  always_comb begin
    rd_val = 64'd0;
    if (is_fix)       rd_val = fix_q[fidx];
    else if (is_attr) rd_val = attr_q;
    else if (is_ctrl) rd_val = ctrl_q;
    else if (is_cap)  rd_val = CAP_VAL;
    else if (is_var)  rd_val = (is_mask ? vmask_q[vidx] : vbase_q[vidx]) & PA_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      attr_q  <= '0;
      fix_q   <= '0;
      vbase_q <= '0;
      vmask_q <= '0;
      rdata   <= '0;
      err     <= 1'b0;
    end else begin
      rdata <= (rd_en && hit) ? rd_val : 64'd0;
      err   <= (wr_en && !(hit && wr_ok)) || (rd_en && !hit);
      if (wr_en && hit && wr_ok) begin
        if (is_fix)       fix_q[fidx] <= wdata;
        else if (is_attr) attr_q      <= wdata;
        else if (is_ctrl) ctrl_q      <= wdata;
        else if (is_var) begin
          if (is_mask) vmask_q[vidx] <= wdata | HI_BITS;
          else         vbase_q[vidx] <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/memtype_regfile_chk.sv
module memtype_regfile_chk #(
  parameter int PA_WIDTH = 36,
  parameter int NUM_VAR  = 8,
  parameter int ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CAP_ADDR = 12'h0FE
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             addr,
  input logic                          wr_en,
  input logic                          rd_en,
  input logic [63:0]                   rdata,
  input logic                          err,
  input logic [63:0]                   ctrl_q,
  input logic [10:0][63:0]             fix_q,
  input logic [NUM_VAR-1:0][63:0]      vmask_q
);
  localparam logic [63:0] HI_BITS = ~((64'd1 << PA_WIDTH) - 64'd1);
  localparam logic [63:0] CAP_VAL = 64'h500 | 64'(NUM_VAR);

  function automatic logic t_ok(input logic [7:0] t);
    return (t == 8'd0) || (t == 8'd1) || (t == 8'd4) || (t == 8'd5) || (t == 8'd6);
  endfunction

  function automatic logic word_ok(input logic [63:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) ok = ok & t_ok(v[i*8 +: 8]);
    return ok;
  endfunction

  for (genvar i = 0; i < 11; i++) begin : g_fix
    assert_fixed_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      word_ok(fix_q[i]));
  end

  for (genvar i = 0; i < NUM_VAR; i++) begin : g_mask
    assert_mask_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vmask_q[i] == 64'd0) || ((vmask_q[i] & HI_BITS) == HI_BITS));
  end

  assert_ctrl_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & ~64'hCFF) == 64'd0) && t_ok(ctrl_q[7:0]));

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |=> !err);

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == 64'd0));

  assert_cap_const_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == CAP_ADDR) |=> (rdata == CAP_VAL) && !err);
endmodule

bind memtype_regfile memtype_regfile_chk #(
  .PA_WIDTH(PA_WIDTH), .NUM_VAR(NUM_VAR), .ADDR_W(ADDR_W), .CAP_ADDR(CAP_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .err(err), .ctrl_q(ctrl_q), .fix_q(fix_q), .vmask_q(vmask_q)
);

// File: tb/memtype_regfile_bench.sv
module memtype_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [63:0] rdata;
  logic        err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [63:0] d; logic e; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  memtype_regfile u_memtype_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .err(err)
  );

  task automatic cyc(input logic [11:0] a, input logic [63:0] d, input logic w, input logic r,
                     input logic [63:0] ed, input logic ee, input string tag);
    exp_t it;
    @(negedge clk);
    addr = a; wdata = d; wr_en = w; rd_en = r;
    it.d = ed; it.e = ee; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic ee, input string tag);
    cyc(a, d, 1'b1, 1'b0, 64'd0, ee, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] ed, input logic ee, input string tag);
    cyc(a, 64'd0, 1'b0, 1'b1, ed, ee, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (rdata !== it.d || err !== it.e) begin
          fails++;
          $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b", it.tag, rdata, err, it.d, it.e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(12'h0FE, 64'h508, 1'b0, "R1");
    rd(12'h100, 64'd0, 1'b0, "R1");
    rd(12'h1F0, 64'd0, 1'b0, "R1");
    rd(12'h1F8, 64'd0, 1'b0, "R1");
    rd(12'h200, 64'd0, 1'b0, "R1");
    rd(12'h201, 64'd0, 1'b0, "R1");
    cyc(12'h0, 64'd0, 1'b0, 1'b0, 64'd0, 1'b0, "R2");
    // R3 fixed ranges
    wr(12'h100, 64'h0605_0401_0001_0406, 1'b0, "R3");
    wr(12'h100, 64'h0605_0401_0001_0206, 1'b1, "R3");
    wr(12'h100, 64'h0705_0401_0001_0406, 1'b1, "R3");
    rd(12'h100, 64'h0605_0401_0001_0406, 1'b0, "R3");
    wr(12'h10A, 64'h0101_0101_0505_0505, 1'b0, "R3");
    rd(12'h10A, 64'h0101_0101_0505_0505, 1'b0, "R3");
    cyc(12'h0, 64'd0, 1'b0, 1'b0, 64'd0, 1'b0, "R2");
    // R4 page attribute
    wr(12'h1F8, 64'h0706_0504_0100_0706, 1'b0, "R4");
    wr(12'h1F8, 64'h0706_0504_0103_0706, 1'b1, "R4");
    rd(12'h1F8, 64'h0706_0504_0100_0706, 1'b0, "R4");
    // R5 control
    wr(12'h1F0, 64'hC06, 1'b0, "R5");
    wr(12'h1F0, 64'h1006, 1'b1, "R5");
    wr(12'h1F0, 64'hC03, 1'b1, "R5");
    rd(12'h1F0, 64'hC06, 1'b0, "R5");
    // R6 variable base
    wr(12'h200, 64'hF_FFFF_F006, 1'b0, "R6");
    wr(12'h200, 64'h1000_0000_0006, 1'b1, "R6");
    wr(12'h200, 64'h106, 1'b1, "R6");
    wr(12'h200, 64'h002, 1'b1, "R6");
    rd(12'h200, 64'hF_FFFF_F006, 1'b0, "R6");
    wr(12'h20E, 64'h007, 1'b1, "R6");
    rd(12'h20E, 64'd0, 1'b0, "R6");
    // R7 / R8 variable mask
    wr(12'h201, 64'hF_FFFF_F800, 1'b0, "R7");
    wr(12'h201, 64'h400, 1'b1, "R7");
    wr(12'h201, 64'h10_0000_0800, 1'b1, "R7");
    rd(12'h201, 64'hF_FFFF_F800, 1'b0, "R8");
    wr(12'h20F, 64'hF_0000_0800, 1'b0, "R8");
    rd(12'h20F, 64'hF_0000_0800, 1'b0, "R8");
    // R9 capability
    wr(12'h0FE, 64'h123, 1'b0, "R9");
    rd(12'h0FE, 64'h508, 1'b0, "R9");
    // R10 unmapped
    rd(12'h210, 64'd0, 1'b1, "R10");
    wr(12'h210, 64'h6, 1'b1, "R10");
    wr(12'h10B, 64'h6, 1'b1, "R10");
    rd(12'h10B, 64'd0, 1'b1, "R10");
    rd(12'h1F1, 64'd0, 1'b1, "R10");
    rd(12'h10A, 64'h0101_0101_0505_0505, 1'b0, "R10");
    // R11 same-cycle read and write
    cyc(12'h100, 64'd0, 1'b1, 1'b1, 64'h0605_0401_0001_0406, 1'b0, "R11");
    rd(12'h100, 64'd0, 1'b0, "R11");
    cyc(12'h100, 64'h02, 1'b1, 1'b1, 64'd0, 1'b1, "R11");
    rd(12'h100, 64'd0, 1'b0, "R11");
    cyc(12'h0, 64'd0, 1'b0, 1'b0, 64'd0, 1'b0, "R2");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: rdata=%h err=%b expected completion", rdata, err);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule